// File: doc/BRIEF.md
# Time Slot Interchange Switch

This block is a time-division circuit switch for a single TDM trunk that carries `SLOTS` samples per frame. A sample has no header; its arrival position in the frame alone decides where it goes. Each incoming sample is stored in a frame bank at the address of its arrival slot. The completed frame is then read back in a different order. A connection table indexed by output slot picks the order, so each sample leaves in the slot of its destination. Because the table is indexed by output slot, several output slots may name the same input slot, which gives multicast at no extra cost.

Two frame banks alternate roles. One bank fills with the incoming frame while the other drains the frame before it, so in steady state every sample is delayed by exactly one frame. A host loads the connection table through a plain write port. Those writes go to a shadow copy. The shadow copy becomes live only when the banks swap, so no frame is ever switched with a half-updated table. Each table entry has an enable bit. An output slot whose entry is disabled sends the `idle_word` input in place of a sample.

Both sample streams use valid/ready. A sample moves on a cycle when valid and ready are both high. The sender must hold `s_data` while `s_valid` is high and `s_ready` is low. The block holds `m_valid`, `m_data` and `m_last` while `m_ready` is low. The input stalls only when a whole new frame is stored and the previous frame has not yet drained.

Top module: `tsi_switch`

## Requirements
- R1: After reset, `s_ready` is 1 and `m_valid` is 0. Every connection entry is disabled. The first accepted input sample belongs to input slot 0.
- R2: When output entry k is enabled with source slot s, output slot k of a frame carries the sample that arrived in input slot s of the corresponding input frame.
- R3: When output entry k is disabled, output slot k carries the value on `idle_word`.
- R4: Several output entries may name the same source slot. Each of those output slots then carries that one stored sample.
- R5: A table write (`cfg_we` with `cfg_slot` = output slot, `cfg_src` = source slot, `cfg_en` = enable) takes effect at the next bank swap. Output slots still to be read in the current frame keep the old entries. A write in the same cycle as a swap waits for the swap after that.
- R6: While `m_valid` is 1 and `m_ready` is 0, `m_valid`, `m_data` and `m_last` hold their values. When one input frame is fully stored and the previous output frame has not drained, `s_ready` is 0 until that output frame's last sample is taken.
- R7: `m_last` is 1 exactly on output slot `SLOTS-1` of each output frame. Output slots are numbered 0 to `SLOTS-1` in order.
- R8: When no output frame is pending, the first sample of a frame is valid on the output in the cycle after the last sample of the matching input frame is accepted. It is not valid before that. Output frames leave in input frame order, and none is dropped.
- R9: The input slot number advances by one for each accepted sample and wraps to 0 after slot `SLOTS-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_word | input | SAMPLE_W | Sample sent on disabled output slots |
| cfg_we | input | 1 | Connection table write strobe |
| cfg_slot | input | $clog2(SLOTS) | Output slot whose entry is written |
| cfg_src | input | $clog2(SLOTS) | Input slot that feeds that output slot |
| cfg_en | input | 1 | Entry enable; 0 sends `idle_word` |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample can be accepted |
| s_data | input | SAMPLE_W | Input sample |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream accepts output sample |
| m_data | output | SAMPLE_W | Output sample |
| m_last | output | 1 | Marks the final slot of an output frame |

## Verification
The hardest state to reach from the ports has both banks holding frames, the input stalled, and the table rewritten while a frame is only partly drained. The bench gets there in stages. It keeps `m_ready` low while it pushes two whole frames, so `s_ready` drops. It then drains with a stall before every sample. In a separate phase it rewrites the whole table after only part of an output frame has been taken, so the rest of that frame must still follow the old entries. A sweep over a family of affine slot permutations, some with disabled entries, then checks every output slot against a value the bench works out from the frame number and the slot number.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int DEF_SAMPLE_W = 8;
  localparam int DEF_SLOTS    = 32;

  // Which of the two frame banks is currently being filled
  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;
endpackage

// File: rtl/tsi_frame_mem.sv
module tsi_frame_mem #(
  parameter int SAMPLE_W = 8,
  parameter int SLOTS    = 32,
  localparam int SLOT_W  = $clog2(SLOTS)
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic                wr_bank,
  input  logic [SLOT_W-1:0]   wr_addr,
  input  logic [SAMPLE_W-1:0] wr_data,
  input  logic                rd_bank,
  input  logic [SLOT_W-1:0]   rd_addr,
  output logic [SAMPLE_W-1:0] rd_data
);
  localparam int BANKS = 2;

  logic [SAMPLE_W-1:0] bank_q [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [SAMPLE_W-1:0] mem [SLOTS];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(b))) begin
        mem[wr_addr] <= wr_data;
      end
    end

    assign bank_q[b] = mem[rd_addr];
  end

  assign rd_data = bank_q[rd_bank];
endmodule

// File: rtl/tsi_conn_map.sv
module tsi_conn_map #(
  parameter int SLOTS   = 32,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [SLOT_W-1:0] cfg_src,
  input  logic              cfg_en,
  input  logic              load,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [SLOT_W-1:0] ent_src,
  output logic              ent_en
);
  logic [SLOT_W-1:0] shd_src [SLOTS];
  logic              shd_en  [SLOTS];
  logic [SLOT_W-1:0] act_src [SLOTS];
  logic              act_en  [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_entry
    // Shadow copy: host writes land here at any time
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shd_src[g] <= '0;
        shd_en[g]  <= 1'b0;
      end else if (cfg_we && (cfg_slot == SLOT_W'(g))) begin
        shd_src[g] <= cfg_src;
        shd_en[g]  <= cfg_en;
      end
    end

    // Live copy: refreshed only at a bank swap
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act_src[g] <= '0;
        act_en[g]  <= 1'b0;
      end else if (load) begin
        act_src[g] <= shd_src[g];
        act_en[g]  <= shd_en[g];
      end
    end

    AST_LIVE_ENTRY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(act_src[g]) && $stable(act_en[g]))); // R5
  end

  assign ent_src = act_src[rd_slot];
  assign ent_en  = act_en[rd_slot];
endmodule

// File: rtl/tsi_seq.sv
module tsi_seq
  import tsi_pkg::*;
#(
  parameter int SLOTS   = 32,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              m_ready,
  output logic              m_valid,
  output logic              m_last,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [SLOT_W-1:0] rd_slot,
  output logic              wr_bank,
  output logic              s_fire,
  output logic              swap
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  bank_e             bank_q;
  logic [SLOT_W-1:0] wr_slot_q, rd_slot_q;
  logic              wr_full_q, rd_busy_q;
  logic              m_fire, wr_done, rd_free;

  assign s_fire  = s_valid && !wr_full_q;
  assign m_fire  = m_ready && rd_busy_q;
  assign wr_done = wr_full_q || (s_fire && (wr_slot_q == LAST));
  assign rd_free = !rd_busy_q || (m_fire && (rd_slot_q == LAST));
  assign swap    = wr_done && rd_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q    <= BANK_A;
      wr_slot_q <= '0;
      rd_slot_q <= '0;
      wr_full_q <= 1'b0;
      rd_busy_q <= 1'b0;
    end else begin
      if (s_fire) begin
        wr_slot_q <= (wr_slot_q == LAST) ? '0 : wr_slot_q + 1'b1;
      end
      if (m_fire) begin
        rd_slot_q <= (rd_slot_q == LAST) ? '0 : rd_slot_q + 1'b1;
      end
      if (swap) begin
        bank_q    <= (bank_q == BANK_A) ? BANK_B : BANK_A;
        wr_full_q <= 1'b0;
        rd_busy_q <= 1'b1;
      end else begin
        if (s_fire && (wr_slot_q == LAST)) wr_full_q <= 1'b1;
        if (m_fire && (rd_slot_q == LAST)) rd_busy_q <= 1'b0;
      end
    end
  end

  assign s_ready = !wr_full_q;
  assign m_valid = rd_busy_q;
  assign m_last  = rd_busy_q && (rd_slot_q == LAST);
  assign wr_slot = wr_slot_q;
  assign rd_slot = rd_slot_q;
  assign wr_bank = (bank_q == BANK_B);

  AST_WR_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    s_fire |=> (wr_slot_q == (($past(wr_slot_q) == LAST) ? '0 : $past(wr_slot_q) + 1'b1))); // R9
  AST_RD_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    m_fire |=> (rd_slot_q == (($past(rd_slot_q) == LAST) ? '0 : $past(rd_slot_q) + 1'b1))); // R7
  AST_IDLE_RD_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_busy_q |-> (rd_slot_q == '0)); // R7
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int SAMPLE_W = tsi_pkg::DEF_SAMPLE_W,
  parameter int SLOTS    = tsi_pkg::DEF_SLOTS,
  localparam int SLOT_W  = $clog2(SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] idle_word,
  input  logic                cfg_we,
  input  logic [SLOT_W-1:0]   cfg_slot,
  input  logic [SLOT_W-1:0]   cfg_src,
  input  logic                cfg_en,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                m_valid,
  input  logic                m_ready,
  output logic [SAMPLE_W-1:0] m_data,
  output logic                m_last
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0]   wr_slot, rd_slot, ent_src;
  logic                wr_bank, s_fire, swap, ent_en;
  logic [SAMPLE_W-1:0] stored;

  tsi_seq #(.SLOTS(SLOTS)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .m_ready (m_ready),
    .m_valid (m_valid),
    .m_last  (m_last),
    .wr_slot (wr_slot),
    .rd_slot (rd_slot),
    .wr_bank (wr_bank),
    .s_fire  (s_fire),
    .swap    (swap)
  );

  tsi_conn_map #(.SLOTS(SLOTS)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_slot (cfg_slot),
    .cfg_src  (cfg_src),
    .cfg_en   (cfg_en),
    .load     (swap),
    .rd_slot  (rd_slot),
    .ent_src  (ent_src),
    .ent_en   (ent_en)
  );

  tsi_frame_mem #(.SAMPLE_W(SAMPLE_W), .SLOTS(SLOTS)) u_mem (
    .clk     (clk),
    .wr_en   (s_fire),
    .wr_bank (wr_bank),
    .wr_addr (wr_slot),
    .wr_data (s_data),
    .rd_bank (~wr_bank),
    .rd_addr (ent_src),
    .rd_data (stored)
  );

  assign m_data = ent_en ? stored : idle_word;

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_last))); // R6
  AST_FRAME_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && (wr_slot == LAST)) |=> (m_valid || !s_ready)); // R8
  AST_NO_EARLY_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_valid && !(s_valid && s_ready && (wr_slot == LAST))) |=> !m_valid); // R8
  AST_BANKS_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> (wr_bank != $past(wr_bank))); // R8
endmodule

// File: tb/tsi_switch_bench.sv
module tsi_switch_bench;
  localparam int SW  = 8;
  localparam int NS  = 8;
  localparam int AW  = $clog2(NS);
  localparam logic [SW-1:0] IDLE = 8'hA5;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we, cfg_en;
  logic [AW-1:0] cfg_slot, cfg_src;
  logic s_valid, s_ready, m_valid, m_ready, m_last;
  logic [SW-1:0] s_data, m_data;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  // Bench copies of the table: shadow and the one the current output frame uses
  int sh_src [NS];
  bit sh_en  [NS];
  int fr_src [NS];
  bit fr_en  [NS];

  always #5 clk = ~clk;

  tsi_switch #(.SAMPLE_W(SW), .SLOTS(NS)) u_tsi_switch (
    .clk(clk), .rst_n(rst_n), .idle_word(IDLE),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_src(cfg_src), .cfg_en(cfg_en),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
  );

  function automatic logic [SW-1:0] din(int f, int i);
    return SW'(f * NS + i);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cfg(int slot, int src, bit en);
    cfg_we = 1'b1; cfg_slot = AW'(slot); cfg_src = AW'(src); cfg_en = en;
    tick();
    cfg_we = 1'b0;
    sh_src[slot] = src;
    sh_en[slot]  = en;
  endtask

  task automatic latch_map();
    for (int k = 0; k < NS; k++) begin
      fr_src[k] = sh_src[k];
      fr_en[k]  = sh_en[k];
    end
  endtask

  task automatic push(logic [SW-1:0] d);
    bit ok;
    s_valid = 1'b1; s_data = d;
    forever begin
      ok = s_ready;
      tick();
      if (ok) break;
    end
    s_valid = 1'b0;
  endtask

  task automatic push_frame(int f);
    for (int i = 0; i < NS; i++) push(din(f, i));
  endtask

  task automatic pop(int f, int k, bit stall, string req);
    logic [SW-1:0] exp, held;
    exp = fr_en[k] ? din(f, fr_src[k]) : IDLE;
    if (stall) begin
      held = m_data;
      check(m_valid === 1'b1, "R6 valid before stall", int'(m_valid), 1);
      tick();
      check(m_valid === 1'b1 && m_data === held, "R6 hold under stall", int'(m_data), int'(held));
    end
    m_ready = 1'b1;
    while (!m_valid) tick();
    check(m_data === exp, req, int'(m_data), int'(exp));
    check(m_last === (k == NS - 1), "R7 last flag", int'(m_last), int'(k == NS - 1));
    tick();
    m_ready = 1'b0;
  endtask

  task automatic drain(int f, bit stall, string req);
    for (int k = 0; k < NS; k++) pop(f, k, stall, req);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      misses++;
      vectors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_slot = '0; cfg_src = '0; cfg_en = 1'b0;
    s_valid = 1'b0; s_data = '0; m_ready = 1'b0;
    for (int k = 0; k < NS; k++) begin sh_src[k] = 0; sh_en[k] = 1'b0; end
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1: reset state
    check(s_ready === 1'b1, "R1 s_ready after reset", int'(s_ready), 1);
    check(m_valid === 1'b0, "R1 m_valid after reset", int'(m_valid), 0);

    // Phase A: reversal permutation, latency of the first frame (R2, R8)
    for (int k = 0; k < NS; k++) cfg(k, NS - 1 - k, 1'b1);
    for (int i = 0; i < NS - 1; i++) push(din(0, i));
    check(m_valid === 1'b0, "R8 no output before frame end", int'(m_valid), 0);
    push(din(0, NS - 1));
    check(m_valid === 1'b1, "R8 output right after frame end", int'(m_valid), 1);
    latch_map();
    drain(0, 1'b0, "R2 reversal");

    // Phase B: multicast pairs, last two slots disabled (R3, R4)
    for (int k = 0; k < NS; k++) cfg(k, k / 2, k < NS - 2);
    push_frame(1);
    latch_map();
    drain(1, 1'b0, "R4 multicast / R3 idle");

    // Phase C: table rewritten mid-frame (R5)
    for (int k = 0; k < NS; k++) cfg(k, (k + 3) % NS, 1'b1);
    push_frame(2);
    latch_map();
    for (int k = 0; k < 3; k++) pop(2, k, 1'b0, "R5 old map before rewrite");
    for (int k = 0; k < NS; k++) cfg(k, k, k != 0);
    for (int k = 3; k < NS; k++) pop(2, k, 1'b0, "R5 old map after rewrite");
    push_frame(3);
    latch_map();
    drain(3, 1'b0, "R5 new map at swap");

    // Phase E: both banks full, input stalls, output drained under stalls (R6, R8)
    push_frame(4);
    push_frame(5);
    check(s_ready === 1'b0, "R6 input stalls with both banks full", int'(s_ready), 0);
    tick();
    check(s_ready === 1'b0, "R6 input stays stalled", int'(s_ready), 0);
    drain(4, 1'b1, "R8 frame order first");
    check(s_ready === 1'b1, "R6 input resumes after drain", int'(s_ready), 1);
    drain(5, 1'b1, "R8 frame order second");

    // Sweep: affine permutations k -> (a*k + b) mod NS (R2, R3, R9)
    for (int a = 1; a < NS; a += 2) begin
      for (int b = 0; b < NS; b++) begin
        int f;
        f = 6 + (a / 2) * NS + b;
        for (int k = 0; k < NS; k++) cfg(k, (a * k + b) % NS, !(a == 7 && k == b));
        push_frame(f);
        latch_map();
        drain(f, (b % 3) == 0, "R2 R9 sweep");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule